// File: doc/BRIEF.md
# Programmable 32-bit CRC Engine

This block is a CRC accelerator that sits on a simple 32-bit register bus. Software sets a 32-bit divisor polynomial and a start value. It restarts the running checksum from that start value and then pushes message data into a data register. Each push can be a whole 32-bit word or a single byte. The running CRC can be read back at any moment. Each bus write is folded into the checksum in the clock cycle in which it lands. The new value can be read in the very next cycle.

Software CRCs often expect reflected bit order. To serve them, the engine can reverse the input bits before they enter the shift register. The reversal can work within each byte, within each half-word or across the whole word. A separate control bit mirrors the 32-bit result on its way back to the bus. With the whole-word input reversal and the output mirror both on, little-endian words followed by trailing bytes give the reflected CRC-32 or CRC-32C directly. Software applies the final inversion itself. A read never changes the checksum. A partial result can therefore be saved and loaded again later through the start-value register.

Top module: `crcx_unit`

## Requirements
- R1: After reset, DATA (word index 0, byte offset 0x00) reads 0xFFFFFFFF, CONTROL (offset 0x08) reads 0, INIT (offset 0x10) reads 0xFFFFFFFF and POLY (offset 0x14) reads 0x04C11DB7. Unmapped offsets read 0, and bus_rdata is 0 whenever bus_rd is low.
- R2: A write to CONTROL with byte lane 0 enabled and bit 0 set loads the running CRC from INIT. Bit 0 always reads 0. Bits 6:5 (input mode) and bit 7 (output mirror) hold their written values.
- R3: A word write to DATA (bus_be = 4'hF) XORs the formatted word into the CRC. It then performs 32 steps, most significant bit first: shift left by one, and XOR with POLY when the bit shifted out is 1. The result reads back in the next cycle.
- R4: A DATA write with exactly one byte enable feeds the 8 bits of that lane (lane k = bus_wdata[8k+7:8k]). Those bits are XORed into CRC bits 31:24, and 8 steps follow.
- R5: The input mode in CONTROL bits 6:5 applies to word writes as follows. 00 leaves the word unchanged. 01 reverses the bits within each byte. 10 reverses the bits within each 16-bit half. 11 reverses all 32 bits. For a single-byte write, any non-zero mode reverses the bits of that byte.
- R6: When CONTROL bit 7 is set, a DATA read returns the running CRC with bit i moved to bit 31-i. The stored value is not changed.
- R7: A DATA write whose byte enables are neither all four lanes nor exactly one lane leaves the CRC unchanged.
- R8: A DATA read leaves the CRC unchanged. Suppose a partial result is read raw, written to INIT and reloaded through CONTROL bit 0. Feeding the remaining data then gives the same CRC as one continuous run.
- R9: With start value 0xFFFFFFFF, input mode 11 and output mirror on, feed the ASCII string "123456789" as two little-endian words and one byte. The inverted read value is 0xCBF43926 for POLY 0x04C11DB7 and 0xE3069283 for POLY 0x1EDC6F41.
- R10: Writes to INIT and POLY update only the byte lanes whose enables are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW (5) | Byte address; bits AW-1:2 select the register |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables for the write |
| bus_wr | input | 1 | Write strobe, one cycle per transfer |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid in the cycle bus_rd is high |

## Verification
Single words are fed under all four input modes using patterns with asymmetric bit content (a single set bit, alternating bytes, mixed nibbles). Because of this asymmetry, each mode gives a different result, and a swapped byte or half-word shows up. Single bytes are swept over every lane and every mode, which exposes lane selection errors and a missing byte reversal. All sixteen byte-enable values are applied to DATA, so the accepted and ignored shapes are told apart. The two standard check strings, under both polynomials, pin down the end-to-end bit order, and a split run with reload must match the continuous run.

// File: rtl/crcx_pkg.sv
package crcx_pkg;

    localparam int unsigned CW = 32;
    localparam int unsigned NB = CW / 8;

    localparam logic [CW-1:0] INIT_RST = 32'hFFFF_FFFF;
    localparam logic [CW-1:0] POLY_RST = 32'h04C1_1DB7;

    // word indices (byte offset / 4)
    localparam int unsigned IDX_DATA = 0;
    localparam int unsigned IDX_CTRL = 2;
    localparam int unsigned IDX_INIT = 4;
    localparam int unsigned IDX_POLY = 5;

    typedef enum logic [1:0] {
        REV_NONE = 2'b00,
        REV_BYTE = 2'b01,
        REV_HALF = 2'b10,
        REV_WORD = 2'b11
    } rev_mode_e;

    typedef struct packed {
        logic      mirror_out;
        rev_mode_e rev_in;
    } ctrl_t;

    typedef enum logic [2:0] {
        SEL_DATA,
        SEL_CTRL,
        SEL_INIT,
        SEL_POLY,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic       word_wr;
        logic       byte_wr;
        logic [1:0] lane;
    } feed_t;

    function automatic logic [7:0] flip8(input logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = v[7-i];
        return r;
    endfunction

    function automatic logic [CW-1:0] flip_word(input logic [CW-1:0] v);
        logic [CW-1:0] r;
        for (int i = 0; i < CW; i++) r[i] = v[CW-1-i];
        return r;
    endfunction

    function automatic logic [CW-1:0] flip_halves(input logic [CW-1:0] v);
        logic [CW-1:0] r;
        for (int h = 0; h < CW / 16; h++)
            for (int j = 0; j < 16; j++) r[16*h+j] = v[16*h+15-j];
        return r;
    endfunction

    function automatic logic [CW-1:0] flip_bytes(input logic [CW-1:0] v);
        logic [CW-1:0] r;
        for (int b = 0; b < NB; b++) r[8*b +: 8] = flip8(v[8*b +: 8]);
        return r;
    endfunction

    function automatic reg_sel_e decode_idx(input int unsigned idx);
        case (idx)
            IDX_DATA: return SEL_DATA;
            IDX_CTRL: return SEL_CTRL;
            IDX_INIT: return SEL_INIT;
            IDX_POLY: return SEL_POLY;
            default:  return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/crcx_decode.sv
module crcx_decode
    import crcx_pkg::*;
#(
    parameter int unsigned AW = 5
) (
    input  logic [AW-1:0] addr,
    input  logic          wr,
    input  logic [NB-1:0] be,
    output reg_sel_e      sel,
    output feed_t         feed
);
    localparam int unsigned IW = AW - 2;

    logic [IW-1:0] idx;
    logic          full_word;
    logic          one_lane;

    assign idx       = addr[AW-1:2];
    assign full_word = &be;
    assign one_lane  = $countones(be) == 1;

    always_comb begin
        sel = decode_idx(int'(idx));
    end

    always_comb begin
        feed.lane = '0;
        for (int b = 0; b < NB; b++)
            if (be[b]) feed.lane = 2'(b);
        feed.word_wr = wr && (sel == SEL_DATA) && full_word;
        feed.byte_wr = wr && (sel == SEL_DATA) && one_lane;
    end

endmodule

// File: rtl/crcx_infmt.sv
module crcx_infmt
    import crcx_pkg::*;
(
    input  rev_mode_e     mode,
    input  logic [CW-1:0] wdata,
    input  logic [1:0]    lane,
    output logic [CW-1:0] word_out,
    output logic [7:0]    byte_out
);
    logic [7:0] raw_byte;

    always_comb begin
        unique case (mode)
            REV_BYTE: word_out = flip_bytes(wdata);
            REV_HALF: word_out = flip_halves(wdata);
            REV_WORD: word_out = flip_word(wdata);
            default:  word_out = wdata;
        endcase
    end

    assign raw_byte = wdata[8*lane +: 8];
    assign byte_out = (mode == REV_NONE) ? raw_byte : flip8(raw_byte);

endmodule

// File: rtl/crcx_step.sv
module crcx_step
    import crcx_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic [CW-1:0] crc_in,
    input  logic [CW-1:0] poly,
    input  logic [DW-1:0] din,
    output logic [CW-1:0] crc_out
);
    localparam int unsigned SHIFT = CW - DW;

    logic [CW-1:0] aligned;

    assign aligned = CW'(din) << SHIFT;

    always_comb begin
        logic [CW-1:0] c;
        c = crc_in ^ aligned;
        for (int i = 0; i < DW; i++)
            c = c[CW-1] ? ((c << 1) ^ poly) : (c << 1);
        crc_out = c;
    end

endmodule

// File: rtl/crcx_cfg.sv
module crcx_cfg
    import crcx_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  reg_sel_e      sel,
    input  logic          wr,
    input  logic [NB-1:0] be,
    input  logic [CW-1:0] wdata,
    output ctrl_t         ctrl_q,
    output logic [CW-1:0] init_q,
    output logic [CW-1:0] poly_q,
    output logic          reload
);
    assign reload = wr && (sel == SEL_CTRL) && be[0] && wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr && (sel == SEL_CTRL) && be[0]) begin
            ctrl_q.mirror_out <= wdata[7];
            ctrl_q.rev_in     <= rev_mode_e'(wdata[6:5]);
        end
    end

    for (genvar b = 0; b < NB; b++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                init_q[8*b +: 8] <= INIT_RST[8*b +: 8];
                poly_q[8*b +: 8] <= POLY_RST[8*b +: 8];
            end else if (wr && be[b]) begin
                if (sel == SEL_INIT) init_q[8*b +: 8] <= wdata[8*b +: 8];
                if (sel == SEL_POLY) poly_q[8*b +: 8] <= wdata[8*b +: 8];
            end
        end
    end

endmodule

// File: rtl/crcx_unit.sv
module crcx_unit
    import crcx_pkg::*;
#(
    parameter int unsigned AW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] bus_addr,
    input  logic [31:0]   bus_wdata,
    input  logic [3:0]    bus_be,
    input  logic          bus_wr,
    input  logic          bus_rd,
    output logic [31:0]   bus_rdata
);
    reg_sel_e      sel;
    feed_t         feed;
    ctrl_t         ctrl_q;
    logic [CW-1:0] init_q;
    logic [CW-1:0] poly_q;
    logic          reload;
    logic [CW-1:0] crc_q;
    logic [CW-1:0] fmt_word;
    logic [7:0]    fmt_byte;
    logic [CW-1:0] crc_after_word;
    logic [CW-1:0] crc_after_byte;

    crcx_decode #(.AW(AW)) u_decode (
        .addr (bus_addr),
        .wr   (bus_wr),
        .be   (bus_be),
        .sel  (sel),
        .feed (feed)
    );

    crcx_cfg u_cfg (
        .clk    (clk),
        .rst    (rst),
        .sel    (sel),
        .wr     (bus_wr),
        .be     (bus_be),
        .wdata  (bus_wdata),
        .ctrl_q (ctrl_q),
        .init_q (init_q),
        .poly_q (poly_q),
        .reload (reload)
    );

    crcx_infmt u_infmt (
        .mode     (ctrl_q.rev_in),
        .wdata    (bus_wdata),
        .lane     (feed.lane),
        .word_out (fmt_word),
        .byte_out (fmt_byte)
    );

    crcx_step #(.DW(CW)) u_step_word (
        .crc_in  (crc_q),
        .poly    (poly_q),
        .din     (fmt_word),
        .crc_out (crc_after_word)
    );

    crcx_step #(.DW(8)) u_step_byte (
        .crc_in  (crc_q),
        .poly    (poly_q),
        .din     (fmt_byte),
        .crc_out (crc_after_byte)
    );

    always_ff @(posedge clk) begin
        if (rst)               crc_q <= INIT_RST;
        else if (reload)       crc_q <= init_q;
        else if (feed.word_wr) crc_q <= crc_after_word;
        else if (feed.byte_wr) crc_q <= crc_after_byte;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (sel)
                SEL_DATA: bus_rdata = ctrl_q.mirror_out ? flip_word(crc_q) : crc_q;
                SEL_CTRL: bus_rdata = {24'd0, ctrl_q.mirror_out, ctrl_q.rev_in, 5'd0};
                SEL_INIT: bus_rdata = init_q;
                SEL_POLY: bus_rdata = poly_q;
                default:  bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/crcx_chk.sv
module crcx_chk
    import crcx_pkg::*;
#(
    parameter int unsigned AW = 5
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] bus_addr,
    input logic [31:0]   bus_wdata,
    input logic [3:0]    bus_be,
    input logic          bus_wr,
    input logic          bus_rd,
    input logic [31:0]   bus_rdata,
    input logic [31:0]   crc_q,
    input logic [31:0]   init_q
);
    logic data_hit;
    logic ctrl_hit;

    assign data_hit = int'(bus_addr[AW-1:2]) == IDX_DATA;
    assign ctrl_hit = int'(bus_addr[AW-1:2]) == IDX_CTRL;

    // R1
    reset_value_chk: assert property (@(posedge clk)
        rst |=> (crc_q == INIT_RST) && (init_q == INIT_RST));

    // R2
    reload_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && ctrl_hit && bus_be[0] && bus_wdata[0]) |=> crc_q == $past(init_q));

    // R2
    start_bit_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && ctrl_hit) |-> !bus_rdata[0]);

    // R7
    bad_enables_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && data_hit && bus_be != 4'hF && $countones(bus_be) != 1) |=> $stable(crc_q));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && (data_hit || ctrl_hit)) |=> $stable(crc_q));

endmodule

bind crcx_unit crcx_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_be    (bus_be),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .crc_q     (crc_q),
    .init_q    (init_q)
);

// File: tb/crcx_unit_tb.sv
module crcx_unit_tb;

    localparam int AW = 5;
    localparam logic [4:0] A_DATA = 5'h00;
    localparam logic [4:0] A_CTRL = 5'h08;
    localparam logic [4:0] A_INIT = 5'h10;
    localparam logic [4:0] A_POLY = 5'h14;
    localparam logic [4:0] A_NONE = 5'h0C;
    localparam logic [31:0] P32  = 32'h04C11DB7;
    localparam logic [31:0] P32C = 32'h1EDC6F41;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [3:0]    bus_be = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [31:0]   bus_rdata;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    crcx_unit #(.AW(AW)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_be    (bus_be),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata)
    );

    // ---- reference arithmetic ----
    function automatic logic [31:0] m_step(logic [31:0] c, logic [31:0] p, logic [31:0] d, int n);
        logic [31:0] r;
        r = c;
        for (int i = n - 1; i >= 0; i--) begin
            logic fb;
            fb = r[31] ^ d[i];
            r = {r[30:0], 1'b0};
            if (fb) r = r ^ p;
        end
        return r;
    endfunction

    function automatic logic [31:0] m_fmt(logic [31:0] w, int mode);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) begin
            case (mode)
                1: r[i] = w[(i & ~7) + 7 - (i & 7)];
                2: r[i] = w[(i & ~15) + 15 - (i & 15)];
                3: r[i] = w[31 - i];
                default: r[i] = w[i];
            endcase
        end
        return r;
    endfunction

    function automatic logic [7:0] m_rev8(logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7 - i];
        return r;
    endfunction

    // ---- bus tasks ----
    task automatic bus_write(logic [4:0] a, logic [31:0] d, logic [3:0] be);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1; bus_rd = 1'b0;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic bus_read(logic [4:0] a, output logic [31:0] v);
        bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b0;
        #1;
        v = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%08h exp=%08h", req, act, exp);
        end
    endtask

    task automatic restart(int mode, bit mirror);
        bus_write(A_CTRL, {24'd0, mirror, 2'(mode), 5'd1}, 4'h1);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            total++; bad++;
            $display("FAIL watchdog act=%0d exp=done", cycles);
            finish_run();
        end
    end

    logic [31:0] pats [6] = '{32'h0000_0001, 32'h8000_0000, 32'h00FF_00FF,
                              32'h1234_5678, 32'hDEAD_BEEF, 32'hF0E1_D2C3};

    initial begin
        logic [31:0] v, exp, mid, full;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset values
        bus_read(A_DATA, v); check("R1 data", v, 32'hFFFFFFFF);
        bus_read(A_CTRL, v); check("R1 ctrl", v, 32'h0);
        bus_read(A_INIT, v); check("R1 init", v, 32'hFFFFFFFF);
        bus_read(A_POLY, v); check("R1 poly", v, P32);
        bus_read(A_NONE, v); check("R1 unmapped", v, 32'h0);
        @(negedge clk); #1; check("R1 idle rdata", bus_rdata, 32'h0);

        // R3 / R5 word sweep over modes and patterns
        for (int m = 0; m < 4; m++) begin
            for (int p = 0; p < 6; p++) begin
                restart(m, 1'b0);
                bus_write(A_DATA, pats[p], 4'hF);
                bus_read(A_DATA, v);
                exp = m_step(32'hFFFFFFFF, P32, m_fmt(pats[p], m), 32);
                check(m == 0 ? "R3 word" : "R5 word mode", v, exp);
            end
        end

        // R4 / R5 byte sweep over lanes and modes
        for (int m = 0; m < 4; m++) begin
            for (int l = 0; l < 4; l++) begin
                logic [7:0] bv;
                bv = 8'h1D + 8'(l * 37);
                restart(m, 1'b0);
                bus_write(A_DATA, 32'hA5A5A5A5 ^ (32'(bv ^ 8'hA5) << (8 * l)), 4'(1 << l));
                bus_read(A_DATA, v);
                exp = m_step(32'hFFFFFFFF, P32, {24'd0, (m == 0) ? bv : m_rev8(bv)}, 8);
                check(m == 0 ? "R4 byte lane" : "R5 byte mode", v, exp);
            end
        end

        // R6 output mirror, stored value untouched
        restart(0, 1'b0);
        bus_write(A_DATA, 32'h1234_5678, 4'hF);
        exp = m_step(32'hFFFFFFFF, P32, 32'h1234_5678, 32);
        bus_write(A_CTRL, 32'h80, 4'h1);
        bus_read(A_DATA, v); check("R6 mirror on", v, m_fmt(exp, 3));
        bus_write(A_CTRL, 32'h00, 4'h1);
        bus_read(A_DATA, v); check("R6 mirror off", v, exp);

        // R7 all byte-enable shapes
        for (int b = 0; b < 16; b++) begin
            restart(0, 1'b0);
            bus_write(A_DATA, 32'hCAFE_F00D, 4'(b));
            bus_read(A_DATA, v);
            if (b == 15) exp = m_step(32'hFFFFFFFF, P32, 32'hCAFEF00D, 32);
            else if ($countones(4'(b)) == 1)
                exp = m_step(32'hFFFFFFFF, P32, {24'd0, 8'(32'hCAFEF00D >> (8 * $clog2(b)))}, 8);
            else exp = 32'hFFFFFFFF;
            check("R7 enables", v, exp);
        end

        // R2 reload from INIT and control readback
        bus_write(A_INIT, 32'h1234_5678, 4'hF);
        bus_write(A_DATA, 32'h0BAD_0BAD, 4'hF);
        bus_write(A_CTRL, 32'hE1, 4'h1);
        bus_read(A_DATA, v); check("R2 reload", v, m_fmt(32'h12345678, 3));
        bus_read(A_CTRL, v); check("R2 ctrl readback", v, 32'hE0);
        bus_write(A_CTRL, 32'h41, 4'h2);
        bus_read(A_CTRL, v); check("R2 lane0 needed", v, 32'hE0);

        // R10 lane-masked config writes
        bus_write(A_INIT, 32'hAABB_CCDD, 4'hF);
        bus_write(A_INIT, 32'h1122_3344, 4'h5);
        bus_read(A_INIT, v); check("R10 init lanes", v, 32'hAA22CC44);
        bus_write(A_POLY, 32'h0000_0000, 4'h8);
        bus_read(A_POLY, v); check("R10 poly lanes", v, 32'h00C11DB7);

        // R9 standard check strings
        bus_write(A_INIT, 32'hFFFF_FFFF, 4'hF);
        for (int k = 0; k < 2; k++) begin
            bus_write(A_POLY, k == 0 ? P32 : P32C, 4'hF);
            restart(3, 1'b1);
            bus_write(A_DATA, 32'h3433_3231, 4'hF);
            bus_write(A_DATA, 32'h3837_3635, 4'hF);
            bus_write(A_DATA, 32'h0000_0039, 4'h1);
            bus_read(A_DATA, v);
            check(k == 0 ? "R9 crc32" : "R9 crc32c", ~v, k == 0 ? 32'hCBF43926 : 32'hE3069283);
        end

        // R8 read does not disturb; split run with reload matches continuous
        bus_write(A_POLY, P32, 4'hF);
        restart(3, 1'b0);
        bus_write(A_DATA, 32'h0102_0304, 4'hF);
        bus_write(A_DATA, 32'h0000_00AB, 4'h1);
        bus_read(A_DATA, full);
        bus_read(A_DATA, v); check("R8 read stable", v, full);
        restart(3, 1'b0);
        bus_write(A_DATA, 32'h0102_0304, 4'hF);
        bus_read(A_DATA, mid);
        bus_write(A_INIT, 32'h5555_5555, 4'hF);
        restart(3, 1'b0);
        bus_write(A_INIT, mid, 4'hF);
        restart(3, 1'b0);
        bus_write(A_DATA, 32'h0000_00AB, 4'h1);
        bus_read(A_DATA, v); check("R8 split resume", v, full);

        finish_run();
    end

endmodule